// File: doc/BRIEF.md
# GPIO Port Bank Controller

This block is the runtime register side of a general-purpose I/O unit with 29 pins, grouped into byte-wide ports. Pin `n` belongs to port `n/8` at bit `n%8`. A host reaches the port data registers with single-cycle requests. An address is inside the runtime window when it lies between the supplied `base` and `base + 0x2C`. A separate configuration block supplies three per-pin controls: output enable, push-pull versus open-drain drive, and pull-up. From these and the output latches, the block drives a value/enable pair for every pad. It also synchronises the pad inputs into the clock domain.

A small state machine runs the read path and has two states. `ST_IDLE` means no read data is presented. `ST_RDATA` means `rdata` holds the byte for the read accepted on the previous edge. Transition `IDLE_TO_RDATA` is taken on a read inside the window. Transition `RDATA_HOLD` is taken when another read arrives while in `ST_RDATA`, so back-to-back reads stream one byte per cycle. Transition `RDATA_TO_IDLE` is taken when a cycle carries no read. Writes inside the window update the latches on the edge that accepts them and do not involve the state machine.

When a pin's output is enabled, reading returns its latch. When the pin is tri-stated, reading returns its sampled level. A write loads only the latches of output-enabled pins. Together these rules make a read-modify-write of one bit leave every other pin as it was.

Top module: `gpio_port_bank`

## Requirements
- R1: A request whose address is below `base` or at `base + 0x2C` and above gets no read response (`rvalid` stays 0), and a write request at such an address changes no latch.
- R2: The port data registers sit at window offsets 0x00, 0x04, 0x08 and 0x0A for ports 0, 1, 2 and 3. Bit `j` of port `p` is pin `8*p + j`.
- R3: Inside the window, any offset other than the four port offsets reads as 0x00 with `rvalid` set, and a write to such an offset changes no latch.
- R4: A read accepted on one clock edge presents `rvalid` = 1 and its data during the following cycle. In a cycle that carries no accepted read on the previous edge, `rvalid` is 0 and `rdata` is 0x00. Back-to-back reads give one response per cycle.
- R5: The read value of a pin is its latch when its output enable is 1. When output enable is 0, the read value is 1 if pull-up is 1, and otherwise the pad input after a two-flop synchroniser.
- R6: A write loads bit `j` of the data into the latch of pin `8*p+j` only when that pin's output enable is 1. Latches of tri-stated pins hold, so a read-modify-write of one bit changes only that pin.
- R7: When output enable = 1 and push-pull = 1, the pin has `pad_oe` = 1 and `pad_out` equal to its latch.
- R8: When output enable = 1 and push-pull = 0 (open-drain), the pin has `pad_out` = 0 and `pad_oe` equal to the inverse of its latch, so it never drives high.
- R9: When output enable = 0, the pin has `pad_oe` = 0 and `pad_out` = 0.
- R10: Port 3 has pins only at bits 0 to 4, and bits 7:5 of a port 3 read are 0.
- R11: After reset all latches are 0, `rvalid` is 0 and `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base | input | 16 | Base address of the runtime window |
| req | input | 1 | Access request, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rvalid` is 1 |
| rvalid | output | 1 | Read response strobe |
| cfg_oe | input | 29 | Per-pin output enable |
| cfg_pp | input | 29 | Per-pin push-pull select (0 = open-drain) |
| cfg_pu | input | 29 | Per-pin pull-up enable |
| pin_in | input | 29 | Pad input levels (asynchronous) |
| pad_out | output | 29 | Pad drive value |
| pad_oe | output | 29 | Pad drive enable |

## Verification
Some pad rules hold on every cycle, and the embedded assertions check them continuously. An open-drain pin never drives high, and a tri-stated pin never drives at all. The assertions also check on every cycle that a response follows only an accepted in-window read, that a miss or an undefined offset causes no write, and that port 3's missing bits read 0. The bench scenarios are needed for the actual data values: the irregular port offsets, latch contents seen through push-pull and open-drain pads, the pull-up and synchroniser latency on tri-stated pins, and the read-modify-write sequence that shows only the target pin moves.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PORT_W    = 8;
    localparam int WIN_BYTES = 'h2C;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RDATA = 1'b1
    } rd_state_t;

    // Window offset of each port's data register (irregular spacing).
    function automatic logic [7:0] port_offset(input int p);
        case (p)
            0:       port_offset = 8'h00;
            1:       port_offset = 8'h04;
            2:       port_offset = 8'h08;
            default: port_offset = 8'h0A;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W      = 29,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CW = W * STAGES;

    logic [CW-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[CW-W-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[CW-1 -: W];

endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int AW     = 16,
    parameter int NPORTS = 4,
    parameter int PIDX_W = 2
) (
    input  logic [AW-1:0]     addr,
    input  logic [AW-1:0]     base,
    output logic              win_hit,
    output logic              port_hit,
    output logic [PIDX_W-1:0] port_idx
);
    logic [AW-1:0] off;

    always_comb begin
        off      = addr - base;
        win_hit  = (addr >= base) && (off < AW'(WIN_BYTES));
        port_hit = 1'b0;
        port_idx = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (win_hit && (off == AW'(port_offset(p)))) begin
                port_hit = 1'b1;
                port_idx = PIDX_W'(p);
            end
        end
    end

endmodule

// File: rtl/gpio_bank_pad.sv
module gpio_bank_pad #(
    parameter int NPINS = 29
) (
    input  logic [NPINS-1:0] latch,
    input  logic [NPINS-1:0] cfg_oe,
    input  logic [NPINS-1:0] cfg_pp,
    input  logic [NPINS-1:0] cfg_pu,
    input  logic [NPINS-1:0] pin_sync,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] rb
);
    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            // push-pull drives the latch; open-drain only pulls low
            assign pad_oe[i]  = cfg_oe[i] & (cfg_pp[i] | ~latch[i]);
            assign pad_out[i] = cfg_oe[i] & cfg_pp[i] & latch[i];
            // enabled pins read their latch, others the sampled level
            assign rb[i]      = cfg_oe[i] ? latch[i] : (cfg_pu[i] | pin_sync[i]);
        end
    endgenerate

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int AW          = 16,
    parameter int NPINS       = 29,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    base,
    input  logic             req,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             rvalid,
    input  logic [NPINS-1:0] cfg_oe,
    input  logic [NPINS-1:0] cfg_pp,
    input  logic [NPINS-1:0] cfg_pu,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    localparam int NPORTS    = (NPINS + PORT_W - 1) / PORT_W;
    localparam int PIDX_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int PADDED    = NPORTS * PORT_W;
    localparam int LAST_BITS = NPINS - (NPORTS - 1) * PORT_W;
    localparam logic [7:0] LAST_MASK = 8'((16'h1 << LAST_BITS) - 16'h1);

    logic              win_hit, port_hit;
    logic [PIDX_W-1:0] port_idx;
    logic              rd_hit, wr_hit;
    logic [NPINS-1:0]  latch_q;
    logic [NPINS-1:0]  pin_sync;
    logic [NPINS-1:0]  rb;
    logic [PADDED-1:0] rb_pad;
    logic [7:0]        rd_byte;
    logic [7:0]        rdata_q;
    rd_state_t         state_q, state_d;

    gpio_bank_decode #(.AW(AW), .NPORTS(NPORTS), .PIDX_W(PIDX_W)) u_dec (
        .addr     (addr),
        .base     (base),
        .win_hit  (win_hit),
        .port_hit (port_hit),
        .port_idx (port_idx)
    );

    gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_bank_pad #(.NPINS(NPINS)) u_pad (
        .latch    (latch_q),
        .cfg_oe   (cfg_oe),
        .cfg_pp   (cfg_pp),
        .cfg_pu   (cfg_pu),
        .pin_sync (pin_sync),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .rb       (rb)
    );

    assign rd_hit = req & ~wr & win_hit;
    assign wr_hit = req &  wr & win_hit;

    // Output latches: only enabled pins of the addressed port load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_hit && port_hit) begin
            for (int i = 0; i < NPINS; i++) begin
                if ((int'(port_idx) == i / PORT_W) && cfg_oe[i])
                    latch_q[i] <= wdata[i % PORT_W];
            end
        end
    end

    // Read byte selection, absent pins padded with zero.
    always_comb begin
        rb_pad              = '0;
        rb_pad[NPINS-1:0]   = rb;
        rd_byte             = 8'h00;
        if (port_hit)
            rd_byte = rb_pad[int'(port_idx) * PORT_W +: PORT_W];
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rd_hit)  state_d = ST_RDATA;  // IDLE_TO_RDATA
            ST_RDATA: if (!rd_hit) state_d = ST_IDLE;   // RDATA_TO_IDLE, else RDATA_HOLD
        endcase
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= 8'h00;
        else        rdata_q <= rd_hit ? rd_byte : 8'h00;
    end

    assign rdata  = rdata_q;
    assign rvalid = (state_q == ST_RDATA);

    // ---------------- assertions ----------------
    a_r1_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && !win_hit) |=> $stable(latch_q));

    a_r3_undef_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && win_hit && !port_hit) |=> $stable(latch_q));

    a_r3_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && $past(win_hit && !port_hit)) |-> (rdata == 8'h00));

    a_r4_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(req && !wr && win_hit));

    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == 8'h00));

    a_r6_tristate_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((latch_q ^ $past(latch_q)) & ~$past(cfg_oe)) == '0);

    a_r8_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_out & ~cfg_pp) == '0);

    a_r9_tristate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~cfg_oe) == '0);

    a_r10_last_port_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && $past(port_hit && (int'(port_idx) == NPORTS - 1)))
            |-> ((rdata & ~LAST_MASK) == 8'h00));

endmodule

// File: tb/sim_gpio_port_bank.sv
`timescale 1ns/1ps
module sim_gpio_port_bank;

    localparam logic [15:0] BASE = 16'h0A40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] base = BASE;
    logic        req = 1'b0, wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rvalid;
    logic [28:0] cfg_oe = '0, cfg_pp = '0, cfg_pu = '0, pin_in = '0;
    logic [28:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_port_bank u0 (
        .clk(clk), .rst_n(rst_n), .base(base), .req(req), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .cfg_oe(cfg_oe), .cfg_pp(cfg_pp), .cfg_pu(cfg_pu), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); req = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); req = 0; wr = 0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] d, output logic v);
        @(negedge clk); req = 1; wr = 0; addr = a;
        @(negedge clk); v = rvalid; d = rdata; req = 0;
    endtask

    task automatic t_reset;
        check("R11 rvalid", 32'(rvalid), 0);
        check("R11 rdata", 32'(rdata), 0);
        check("R9 pad_oe after reset", 32'(pad_oe), 0);
        check("R11 pad_out after reset", 32'(pad_out), 0);
    endtask

    task automatic t_pushpull;
        logic [7:0] d; logic v;
        cfg_oe[7:0] = 8'hFF; cfg_pp[7:0] = 8'hFF;
        do_write(BASE + 16'h00, 8'hA5);
        check("R7 pad_out port0", 32'(pad_out[7:0]), 32'hA5);
        check("R7 pad_oe port0", 32'(pad_oe[7:0]), 32'hFF);
        do_read(BASE + 16'h00, d, v);
        check("R4 rvalid port0", 32'(v), 1);
        check("R5 readback port0", 32'(d), 32'hA5);
    endtask

    task automatic t_opendrain;
        logic [7:0] d; logic v;
        cfg_oe[15:8] = 8'hFF; cfg_pp[15:8] = 8'h00;
        do_write(BASE + 16'h04, 8'h3C);
        check("R8 od pad_oe", 32'(pad_oe[15:8]), 32'hC3);
        check("R8 od pad_out", 32'(pad_out[15:8]), 0);
        do_read(BASE + 16'h04, d, v);
        check("R5 od readback", 32'(d), 32'h3C);
    endtask

    task automatic t_offsets;
        logic [7:0] d; logic v;
        cfg_oe[23:16] = 8'hFF; cfg_pp[23:16] = 8'hFF;
        cfg_oe[28:24] = 5'h1F; cfg_pp[28:24] = 5'h1F;
        do_write(BASE + 16'h08, 8'h5A);
        check("R2 port2 at 0x08", 32'(pad_out[23:16]), 32'h5A);
        do_write(BASE + 16'h0A, 8'hFF);
        check("R2 port3 at 0x0A", 32'(pad_out[28:24]), 32'h1F);
        do_read(BASE + 16'h0A, d, v);
        check("R10 port3 upper bits zero", 32'(d), 32'h1F);
        check("R2 port0 untouched", 32'(pad_out[7:0]), 32'hA5);
    endtask

    task automatic t_rmw;
        logic [7:0] d; logic v;
        do_read(BASE + 16'h00, d, v);
        do_write(BASE + 16'h00, d | 8'h02);
        check("R6 rmw port0", 32'(pad_out[7:0]), 32'hA7);
        // tri-stated pin 17 keeps its latch through a port write
        cfg_oe[17] = 1'b0;
        do_write(BASE + 16'h08, 8'h00);
        check("R9 pin17 released", 32'(pad_oe[17]), 0);
        @(negedge clk); cfg_oe[17] = 1'b1; #1;
        check("R6 tri-stated latch held", 32'(pad_out[23:16]), 32'h02);
    endtask

    task automatic t_tristate_read;
        logic [7:0] d; logic v;
        cfg_oe[15:8] = 8'h00; cfg_pu[15:8] = 8'hF0; pin_in[15:8] = 8'h05;
        repeat (3) @(negedge clk);
        #1;
        check("R9 port1 tri-stated", 32'(pad_oe[15:8]), 0);
        do_read(BASE + 16'h04, d, v);
        check("R5 pull-up and sampled input", 32'(d), 32'hF5);
        // synchroniser latency: change, read one cycle later sees old value
        @(negedge clk); pin_in[8] = 1'b0; req = 1; wr = 0; addr = BASE + 16'h04;
        @(negedge clk); d = rdata; req = 0;
        check("R5 sync not yet through", 32'(d), 32'hF5);
        repeat (2) @(negedge clk);
        do_read(BASE + 16'h04, d, v);
        check("R5 sync after two stages", 32'(d), 32'hF4);
    endtask

    task automatic t_undef;
        logic [7:0] d; logic v;
        logic [28:0] snap;
        snap = pad_out;
        do_read(BASE + 16'h01, d, v);
        check("R3 undef read valid", 32'(v), 1);
        check("R3 undef read zero", 32'(d), 0);
        do_write(BASE + 16'h01, 8'h00);
        do_write(BASE + 16'h2B, 8'h00);
        check("R3 undef write ignored", 32'(pad_out), 32'(snap));
        do_read(BASE + 16'h2B, d, v);
        check("R3 last window byte reads zero", 32'(d), 0);
    endtask

    task automatic t_window;
        logic [7:0] d; logic v;
        logic [28:0] snap;
        snap = pad_out;
        do_read(BASE + 16'h2C, d, v);
        check("R1 read past window", 32'(v), 0);
        do_read(BASE - 16'h04, d, v);
        check("R1 read below base", 32'(v), 0);
        do_write(BASE - 16'h40, 8'h00);
        do_write(BASE + 16'h30, 8'h00);
        check("R1 miss writes ignored", 32'(pad_out), 32'(snap));
    endtask

    task automatic t_stream;
        logic [7:0] d0, d1;
        @(negedge clk); req = 1; wr = 0; addr = BASE + 16'h00;
        @(negedge clk); d0 = rdata; check("R4 first stream valid", 32'(rvalid), 1);
        addr = BASE + 16'h08;
        @(negedge clk); d1 = rdata; check("R4 second stream valid", 32'(rvalid), 1);
        req = 0;
        check("R4 stream data0", 32'(d0), 32'hA7);
        check("R4 stream data1", 32'(d1), 32'h02);
        @(negedge clk);
        check("R4 rvalid drops", 32'(rvalid), 0);
        check("R4 rdata idle zero", 32'(rdata), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pushpull();
        t_opendrain();
        t_offsets();
        t_rmw();
        t_tristate_read();
        t_undef();
        t_window();
        t_stream();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule